// File: doc/BRIEF.md
# Inverted Page Table Search Engine

This block resolves a translation miss by walking a global inverted page table. The table holds one 32-bit word per physical page frame, and the position of a word in the table is the frame number it describes. The frame number is not stored anywhere in the word. It comes from where the matching word sits.

A miss request carries a 20-bit virtual page number, the 12-bit page offset and an access type. The engine reads the table one word per cycle through a synchronous read port with one cycle of latency. It starts at index 0 and stops at the first word whose valid bit is set and whose stored page number equals the requested one. It then reports one of three outcomes:
- a hit, with the frame number, the protection bits and the physical address (frame concatenated with offset);
- a protection fault, when the matching word does not permit the requested access;
- a not-resident fault, when no word matches, so that software can bring the page in.

Only one request is in flight at a time. The controller is a four-state machine:
- `S_IDLE`: waiting, `req_ready` high. It moves to `S_ISSUE` when a request arrives.
- `S_ISSUE`: reads index 0. It always moves to `S_CHECK`.
- `S_CHECK`: examines the returned word and, on a non-match, reads the next index in the same cycle. It stays in `S_CHECK` while there is no match and the current index is not the last. It moves to `S_REPORT` on a match or after the last index.
- `S_REPORT`: pulses `done`. It always returns to `S_IDLE`.

Top module: `ipt_search_engine`

## Requirements
- R1: After reset, req_ready is 1 and done, hit, fault, frame, perm, phys_addr, mem_rd_en and probe_count are all 0.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle through the cycle in which done is 1, and is 1 again in the cycle after that.
- R3: Table reads start at index 0 and rise by one per cycle, with no gaps. Data returns one cycle after mem_rd_en. done rises in the cycle probe_count+2 cycles after the accepting edge, counting the cycle just after that edge as the first.
- R4: Entry layout is as follows:
  - bits 31:12 hold the virtual page number;
  - bit 0 is the valid bit;
  - bit 1 grants read, bit 2 grants write and bit 3 grants execute;
  - bits 11:4 are reserved and have no effect on matching.
- R5: On a permitted match, hit=1, fault=0, frame is the index of the matching entry, perm is entry bits 3:1 (execute, write, read), and phys_addr is {frame, offset}.
- R6: When several valid entries hold the requested page number, the lowest index is reported.
- R7: When no entry matches, the result is as follows:
  - fault=1 (not resident) and hit=0;
  - frame, perm and phys_addr are 0;
  - probe_count equals the table size.
- R8: Access codes are 0 read, 1 write, 2 execute and 3 never permitted. On a match that lacks the required permission, the result is as follows:
  - fault=2 (protection) and hit=0;
  - frame and perm are those of the matching entry;
  - phys_addr is 0.
- R9: done is a one-cycle pulse. hit, fault, frame, perm and phys_addr keep their values in the following cycles.
- R10: probe_count clears when a request is accepted and counts the reads issued for that request. A match at index k leaves it at k+1.
- R11: An entry whose valid bit is 0 never matches, even when its page number equals the requested one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_vpn | input | 20 | Virtual page number to find |
| req_offset | input | 12 | Page offset carried into the physical address |
| req_access | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 none |
| mem_rd_en | output | 1 | Table read strobe |
| mem_rd_addr | output | 10 | Table index to read |
| mem_rd_data | input | 32 | Table word, valid one cycle after the strobe |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Translation found and permitted |
| frame | output | 10 | Physical frame number (matching index) |
| perm | output | 3 | Execute, write and read bits of the matching entry |
| fault | output | 2 | 0 none, 1 not resident, 2 protection |
| phys_addr | output | 22 | {frame, offset} on a hit, else 0 |
| probe_count | output | 11 | Reads issued for the current request |

## Verification
The table is filled with unique background page numbers. The bench then plants targets at these positions:
- the first index, which isolates the start of the scan;
- an interior index, which isolates a single-permission entry;
- the last index, which isolates the boundary of the counter and address;
- behind an invalid twin, which separates the valid check from the compare;
- behind a duplicate, which separates first-match priority from last-match.

Each target is requested with permitted and forbidden access codes, so protection faults are told apart from hits on the same entry. An absent page drives the full scan to the not-resident fault. Reserved bits are set on one target to show they are ignored. The completion latency and the address sequence are checked against the probe count on every request, which exposes skipped or repeated reads.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_NONE  = 2'd3
    } access_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_PROT   = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_CHECK,
        S_REPORT
    } scan_state_e;

    localparam int VALID_POS = 0;
    localparam int PERM_POS  = 1;
    localparam int PERM_W    = 3;

endpackage

// File: rtl/ipt_scan_fsm.sv
module ipt_scan_fsm
    import ipt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic entry_match,
    input  logic at_last,
    output logic req_ready,
    output logic accept,
    output logic rd_en,
    output logic sel_next,
    output logic step,
    output logic finish,
    output logic done
);

    scan_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        accept    = 1'b0;
        rd_en     = 1'b0;
        sel_next  = 1'b0;
        step      = 1'b0;
        finish    = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    accept  = 1'b1;
                    state_d = S_ISSUE;
                end
            end
            S_ISSUE: begin
                rd_en   = 1'b1;
                state_d = S_CHECK;
            end
            S_CHECK: begin
                if (entry_match || at_last) begin
                    finish  = 1'b1;
                    state_d = S_REPORT;
                end else begin
                    rd_en    = 1'b1;
                    sel_next = 1'b1;
                    step     = 1'b1;
                end
            end
            S_REPORT: begin
                done    = 1'b1;
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

endmodule

// File: rtl/ipt_scan_index.sv
module ipt_scan_index #(
    parameter int ENTRIES = 1024,
    parameter int FRAME_W = $clog2(ENTRIES),
    parameter int PROBE_W = $clog2(ENTRIES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               step,
    input  logic               count_rd,
    output logic [FRAME_W-1:0] idx,
    output logic [FRAME_W-1:0] idx_next,
    output logic               at_last,
    output logic [PROBE_W-1:0] probes
);

    localparam logic [FRAME_W-1:0] LAST_IDX = FRAME_W'(ENTRIES - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clear) begin
            idx <= '0;
        end else if (step) begin
            idx <= idx_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            probes <= '0;
        end else if (clear) begin
            probes <= '0;
        end else if (count_rd) begin
            probes <= probes + 1'b1;
        end
    end

    always_comb begin
        idx_next = idx + 1'b1;
        at_last  = (idx == LAST_IDX);
    end

endmodule

// File: rtl/ipt_entry_match.sv
module ipt_entry_match
    import ipt_pkg::*;
#(
    parameter int VPN_W  = 20,
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] entry,
    input  logic [VPN_W-1:0]  vpn,
    input  logic [1:0]        access,
    output logic              match,
    output logic              permitted,
    output logic [PERM_W-1:0] perm
);

    always_comb begin
        perm  = entry[PERM_POS +: PERM_W];
        match = entry[VALID_POS] && (entry[WORD_W-1 -: VPN_W] == vpn);
        unique case (access_e'(access))
            ACC_READ:  permitted = perm[0];
            ACC_WRITE: permitted = perm[1];
            ACC_EXEC:  permitted = perm[2];
            ACC_NONE:  permitted = 1'b0;
            default:   permitted = 1'b0;
        endcase
    end

endmodule

// File: rtl/ipt_result_reg.sv
module ipt_result_reg
    import ipt_pkg::*;
#(
    parameter int FRAME_W = 10,
    parameter int OFF_W   = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic                     match,
    input  logic                     permitted,
    input  logic [FRAME_W-1:0]       idx,
    input  logic [PERM_W-1:0]        perm_in,
    input  logic [OFF_W-1:0]         offset,
    output logic                     hit,
    output logic [FRAME_W-1:0]       frame,
    output logic [PERM_W-1:0]        perm,
    output logic [1:0]               fault,
    output logic [FRAME_W+OFF_W-1:0] phys_addr
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit       <= 1'b0;
            frame     <= '0;
            perm      <= '0;
            fault     <= FLT_NONE;
            phys_addr <= '0;
        end else if (load) begin
            if (match) begin
                frame <= idx;
                perm  <= perm_in;
                if (permitted) begin
                    hit       <= 1'b1;
                    fault     <= FLT_NONE;
                    phys_addr <= {idx, offset};
                end else begin
                    hit       <= 1'b0;
                    fault     <= FLT_PROT;
                    phys_addr <= '0;
                end
            end else begin
                hit       <= 1'b0;
                frame     <= '0;
                perm      <= '0;
                fault     <= FLT_ABSENT;
                phys_addr <= '0;
            end
        end
    end

endmodule

// File: rtl/ipt_search_engine.sv
module ipt_search_engine
    import ipt_pkg::*;
#(
    parameter int ENTRIES = 1024,
    parameter int VPN_W   = 20,
    parameter int OFF_W   = 12,
    parameter int WORD_W  = 32,
    parameter int FRAME_W = $clog2(ENTRIES),
    parameter int PROBE_W = $clog2(ENTRIES + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [VPN_W-1:0]         req_vpn,
    input  logic [OFF_W-1:0]         req_offset,
    input  logic [1:0]               req_access,
    output logic                     mem_rd_en,
    output logic [FRAME_W-1:0]       mem_rd_addr,
    input  logic [WORD_W-1:0]        mem_rd_data,
    output logic                     done,
    output logic                     hit,
    output logic [FRAME_W-1:0]       frame,
    output logic [2:0]               perm,
    output logic [1:0]               fault,
    output logic [FRAME_W+OFF_W-1:0] phys_addr,
    output logic [PROBE_W-1:0]       probe_count
);

    logic [VPN_W-1:0]   vpn_q;
    logic [OFF_W-1:0]   off_q;
    logic [1:0]         acc_q;
    logic               accept, sel_next, step, finish;
    logic               entry_match, entry_ok, at_last;
    logic [FRAME_W-1:0] idx, idx_next;
    logic [PERM_W-1:0]  entry_perm;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q <= '0;
            off_q <= '0;
            acc_q <= '0;
        end else if (accept) begin
            vpn_q <= req_vpn;
            off_q <= req_offset;
            acc_q <= req_access;
        end
    end

    ipt_scan_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .entry_match (entry_match),
        .at_last     (at_last),
        .req_ready   (req_ready),
        .accept      (accept),
        .rd_en       (mem_rd_en),
        .sel_next    (sel_next),
        .step        (step),
        .finish      (finish),
        .done        (done)
    );

    ipt_scan_index #(
        .ENTRIES (ENTRIES),
        .FRAME_W (FRAME_W),
        .PROBE_W (PROBE_W)
    ) u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .step     (step),
        .count_rd (mem_rd_en),
        .idx      (idx),
        .idx_next (idx_next),
        .at_last  (at_last),
        .probes   (probe_count)
    );

    ipt_entry_match #(
        .VPN_W  (VPN_W),
        .WORD_W (WORD_W)
    ) u_match (
        .entry     (mem_rd_data),
        .vpn       (vpn_q),
        .access    (acc_q),
        .match     (entry_match),
        .permitted (entry_ok),
        .perm      (entry_perm)
    );

    ipt_result_reg #(
        .FRAME_W (FRAME_W),
        .OFF_W   (OFF_W)
    ) u_result (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (finish),
        .match     (entry_match),
        .permitted (entry_ok),
        .idx       (idx),
        .perm_in   (entry_perm),
        .offset    (off_q),
        .hit       (hit),
        .frame     (frame),
        .perm      (perm),
        .fault     (fault),
        .phys_addr (phys_addr)
    );

    always_comb begin
        mem_rd_addr = sel_next ? idx_next : idx;
    end

    // R3: consecutive reads walk the table one index at a time
    a_r3_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == $past(mem_rd_addr) + 1'b1));

    // R3: every scan starts at index 0
    a_r3_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && !$past(mem_rd_en)) |-> (mem_rd_addr == '0));

    // R5: a hit never carries a fault code
    a_r5_hit_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (done && hit) |-> (fault == FLT_NONE));

    // R7: the probe count never exceeds the table size
    a_r7_probe_bound: assert property (@(posedge clk) disable iff (!rst_n)
        probe_count <= PROBE_W'(ENTRIES));

    // R2: no table traffic while the engine is idle
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_rd_en);

endmodule

// File: tb/ipt_search_engine_bench.sv
module ipt_search_engine_bench;

    localparam int ENTRIES = 1024;
    localparam int NVEC    = 10;

    typedef struct packed {
        logic [19:0] vpn;
        logic [11:0] off;
        logic [1:0]  acc;
        logic        hit;
        logic [9:0]  frame;
        logic [2:0]  perm;
        logic [1:0]  fault;
        logic [10:0] probes;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{20'h80000, 12'h123, 2'd0, 1'b1, 10'd0,    3'd7, 2'd0, 11'd1},
        '{20'h12345, 12'hABC, 2'd0, 1'b1, 10'd5,    3'd1, 2'd0, 11'd6},
        '{20'h12345, 12'h001, 2'd1, 1'b0, 10'd5,    3'd1, 2'd2, 11'd6},
        '{20'h55555, 12'h777, 2'd2, 1'b1, 10'd200,  3'd6, 2'd0, 11'd201},
        '{20'h55555, 12'h010, 2'd0, 1'b0, 10'd200,  3'd6, 2'd2, 11'd201},
        '{20'h0ABCD, 12'hFFF, 2'd1, 1'b1, 10'd300,  3'd7, 2'd0, 11'd301},
        '{20'hFFFFF, 12'h456, 2'd1, 1'b1, 10'd1023, 3'd2, 2'd0, 11'd1024},
        '{20'hFFFFF, 12'h456, 2'd3, 1'b0, 10'd1023, 3'd2, 2'd2, 11'd1024},
        '{20'h00001, 12'h999, 2'd0, 1'b0, 10'd0,    3'd0, 2'd1, 11'd1024},
        '{20'h22222, 12'h321, 2'd2, 1'b1, 10'd7,    3'd4, 2'd0, 11'd8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_vpn = '0;
    logic [11:0] req_offset = '0;
    logic [1:0]  req_access = '0;
    logic        mem_rd_en;
    logic [9:0]  mem_rd_addr;
    logic [31:0] mem_rd_data;
    logic        done, hit;
    logic [9:0]  frame;
    logic [2:0]  perm;
    logic [1:0]  fault;
    logic [21:0] phys_addr;
    logic [10:0] probe_count;

    logic [31:0] table_mem [ENTRIES];
    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= table_mem[mem_rd_addr];
    end

    ipt_search_engine u_ipt_search_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_vpn     (req_vpn),
        .req_offset  (req_offset),
        .req_access  (req_access),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .done        (done),
        .hit         (hit),
        .frame       (frame),
        .perm        (perm),
        .fault       (fault),
        .phys_addr   (phys_addr),
        .probe_count (probe_count)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int n;
        int exp_addr;
        logic addr_bad;
        logic [21:0] exp_phys;
        @(negedge clk);
        req_valid  = 1'b1;
        req_vpn    = v.vpn;
        req_offset = v.off;
        req_access = v.acc;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 ready low after accept", req_ready, 1'b0);
        check("R10 probe cleared on accept", probe_count, 0);
        n = 1;
        exp_addr = 0;
        addr_bad = 1'b0;
        while (!done && n < 1100) begin
            if (mem_rd_en) begin
                if (mem_rd_addr != exp_addr[9:0]) addr_bad = 1'b1;
                exp_addr++;
            end
            @(negedge clk);
            n++;
        end
        exp_phys = v.hit ? {v.frame, v.off} : 22'd0;
        check("R3 address sequence", addr_bad, 1'b0);
        check("R3 latency", n, v.probes + 2);
        check("R10 probe count", probe_count, v.probes);
        check("R5 hit", hit, v.hit);
        check("R5 frame", frame, v.frame);
        check("R5 perm", perm, v.perm);
        check("R8 fault", fault, v.fault);
        check("R5 phys_addr", phys_addr, exp_phys);
        check("R2 ready low at done", req_ready, 1'b0);
        @(negedge clk);
        check("R9 done one cycle", done, 1'b0);
        check("R2 ready back", req_ready, 1'b1);
        check("R9 result held", {hit, frame, perm, fault, phys_addr},
              {v.hit, v.frame, v.perm, v.fault, exp_phys});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R2 watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < ENTRIES; i++) begin
            table_mem[i] = {20'h80000 | 20'(i), 8'h00, 3'b111, 1'b1};
        end
        table_mem[5]    = {20'h12345, 8'h00, 3'b001, 1'b1};
        table_mem[7]    = {20'h22222, 8'hFF, 3'b100, 1'b1};   // R4 reserved bits set
        table_mem[100]  = {20'h55555, 8'h00, 3'b111, 1'b0};   // R11 invalid twin
        table_mem[200]  = {20'h55555, 8'h00, 3'b110, 1'b1};
        table_mem[300]  = {20'h0ABCD, 8'h00, 3'b111, 1'b1};   // R6 duplicates
        table_mem[301]  = {20'h0ABCD, 8'h00, 3'b111, 1'b1};
        table_mem[1023] = {20'hFFFFF, 8'h00, 3'b010, 1'b1};

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 ready", req_ready, 1'b1);
        check("R1 outputs", {done, hit, frame, perm, fault, phys_addr, mem_rd_en, probe_count}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {req_ready, done, mem_rd_en}, 3'b100);

        for (int k = 0; k < NVEC; k++) begin
            run_vec(VECS[k]);
        end

        // R11: invalidate the hit at 200 as well; the page becomes not resident
        table_mem[200][0] = 1'b0;
        run_vec('{20'h55555, 12'h010, 2'd2, 1'b0, 10'd0, 3'd0, 2'd1, 11'd1024});

        // R6: remove the lower duplicate; the next one is found
        table_mem[300][0] = 1'b0;
        run_vec('{20'h0ABCD, 12'h0F0, 2'd0, 1'b1, 10'd301, 3'd7, 2'd0, 11'd302});

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule